// File: doc/BRIEF.md
# Low-Power Sleep Level Sequencer

This block decides which clocks, oscillators and regulator modes stay alive while a microcontroller sleeps. Software picks one of three sleep levels through a two-bit configuration port. The CPU then raises a wait-for-interrupt strobe. The level held in the configuration register at that instant is the one entered. The three levels are light idle, deep standby and full power-off. A configuration write passes through a modelled bus bridge, so the stored level changes a fixed number of cycles after the write.

Each level has its own rule for waking. Light idle wakes on any bus-clock interrupt or on an asynchronous interrupt. Deep standby wakes on an asynchronous interrupt, or on a bus-clock interrupt from a peripheral flagged to keep running in standby. Power-off ignores every wake input and is left only through the external reset.

Standby is never entered while the regulator-ready flag is low. On wake, the enables come back in a fixed staircase, and a one-cycle completion pulse marks the end.

Top module: `slp_seq_top`

## Requirements
- R1: After reset, every clock, generic-clock and oscillator enable is 1. The low-power, regulator-off, NVM-off and completion outputs are 0. The configuration readback is 0.
- R2: Level codes are 0 = idle, 1 = standby, 2 = off. A write sampled on clock edge k shows on the readback after edge k+2. A write of code 3 leaves the stored level unchanged.
- R3: A wait-for-interrupt sampled on an edge uses the level stored at that edge. It ignores any write still in flight.
- R4: In idle, the CPU clock is off and the main clock is on. All generic clocks and all oscillators are on. The bus clock follows the bus-clock request. Low-power mode is off.
- R5: In standby, the CPU clock is off and low-power mode is on. The bus clock follows the bus request, and each generic clock follows its request. The main clock is on only if the bus or any generic clock is requested. Each oscillator is on if it is requested or flagged run-in-standby.
- R6: Idle wakes on any set bit of the synchronous wake vector, or on the asynchronous wake.
- R7: Standby wakes on the asynchronous wake. It also wakes on a synchronous wake bit whose run-in-standby flag is set. A synchronous bit whose flag is clear has no effect.
- R8: In off, every clock and oscillator enable is 0, and the regulator-off and NVM-off outputs are 1. No wake input leaves this level; only reset does.
- R9: A standby request made while regulator-ready is low keeps all clocks running until the flag rises, and standby is then entered. Any idle-class wake during that wait cancels the request and returns to run without the wake staircase.
- R10: After the edge that samples a wake, the enables return in order, one cycle apart. The main clock and all oscillators come first. The bus and all generic clocks come next, then the CPU clock. The completion output is then high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Level code to write |
| cfg_rdata | output | 2 | Stored level code |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the CPU |
| sync_wake | input | NP | Bus-clock interrupt per peripheral |
| async_wake | input | 1 | Combined asynchronous interrupt |
| rstby_mask | input | NP | Run-in-standby flag per peripheral |
| osc_req | input | NO | Oscillator requests |
| osc_rstby | input | NO | Oscillator run-in-standby flags |
| bus_clk_req | input | 1 | Peripheral request for the bus clock |
| gclk_req | input | NG | Peripheral requests for generic clocks |
| vreg_ready | input | 1 | Regulator low-power ready flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| main_clk_en | output | 1 | Main clock enable |
| gclk_en | output | NG | Generic clock enables |
| osc_en | output | NO | Oscillator enables |
| vreg_lp | output | 1 | Regulator low-power mode |
| vreg_off | output | 1 | Regulator off |
| nvm_off | output | 1 | NVM powered down |
| wake_done | output | 1 | One-cycle wake completion pulse |

## Verification
Standby outputs are checked over every combination of oscillator request, oscillator run-in-standby flag, generic-clock request and bus request. This separates the on-demand terms from the fixed ones.

Standby wakes are tried for every synchronous source under every run-in-standby mask. Whether the main clock comes up on the next cycle shows whether the mask gates that source. Idle wakes are tried once per source, including the asynchronous one. Each wake also checks the full four-step staircase.

Three more cases are covered. A write is followed at once by a wait-for-interrupt, which tells the bridge delay apart from the stored level. Standby is requested with the regulator flag low, and the wait is also cancelled. Power-off is held under every wake input.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE = 2'd0,
    LVL_STBY = 2'd1,
    LVL_OFF  = 2'd2,
    LVL_RSVD = 2'd3
  } lvl_e;

  typedef enum logic [3:0] {
    ST_RUN, ST_IDLE, ST_STBY_WAIT, ST_STBY, ST_OFF,
    ST_WK_MAIN, ST_WK_BUS, ST_WK_CPU, ST_WK_DONE
  } st_e;
endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/slp_cfg_bridge.sv
module slp_cfg_bridge
  import slp_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wdata,
  output lvl_e       level
);
  logic [LAT-1:0]      vld_q, vld_d;
  logic [LAT-1:0][1:0] dat_q, dat_d;
  lvl_e                level_q, level_d;

  always_comb begin
    vld_d[0] = wr_en && (wdata != LVL_RSVD);
    dat_d[0] = wdata;
    for (int i = 1; i < LAT; i++) begin
      vld_d[i] = vld_q[i-1];
      dat_d[i] = dat_q[i-1];
    end
    level_d = vld_q[LAT-1] ? lvl_e'(dat_q[LAT-1]) : level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dat_q   <= '0;
      level_q <= LVL_IDLE;
    end else begin
      vld_q   <= vld_d;
      dat_q   <= dat_d;
      level_q <= level_d;
    end
  end

  assign level = level_q;
endmodule

// File: rtl/slp_wake_qual.sv
module slp_wake_qual #(
  parameter int NP = 4
) (
  input  logic [NP-1:0] sync_wake,
  input  logic [NP-1:0] rstby_mask,
  input  logic          async_wake,
  output logic          wake_light,
  output logic          wake_deep
);
  assign wake_light = async_wake | (|sync_wake);
  assign wake_deep  = async_wake | (|(sync_wake & rstby_mask));
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req,
  input  lvl_e level,
  input  logic vreg_ready,
  input  logic wake_light,
  input  logic wake_deep,
  output st_e  state
);
  st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: if (wfi_req) begin
        case (level)
          LVL_IDLE: state_d = ST_IDLE;
          LVL_STBY: state_d = vreg_ready ? ST_STBY : ST_STBY_WAIT;
          LVL_OFF:  state_d = ST_OFF;
          default:  state_d = ST_RUN;
        endcase
      end
      ST_IDLE:      if (wake_light) state_d = ST_WK_MAIN;
      ST_STBY_WAIT: begin
        if (wake_light)      state_d = ST_RUN;
        else if (vreg_ready) state_d = ST_STBY;
      end
      ST_STBY:      if (wake_deep) state_d = ST_WK_MAIN;
      ST_OFF:       state_d = ST_OFF;
      ST_WK_MAIN:   state_d = ST_WK_BUS;
      ST_WK_BUS:    state_d = ST_WK_CPU;
      ST_WK_CPU:    state_d = ST_WK_DONE;
      ST_WK_DONE:   state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/slp_clk_gate.sv
module slp_clk_gate
  import slp_pkg::*;
#(
  parameter int NO = 2,
  parameter int NG = 3
) (
  input  st_e           state,
  input  logic          bus_clk_req,
  input  logic [NG-1:0] gclk_req,
  input  logic [NO-1:0] osc_req,
  input  logic [NO-1:0] osc_rstby,
  output logic          cpu_clk_en,
  output logic          bus_clk_en,
  output logic          main_clk_en,
  output logic [NG-1:0] gclk_en,
  output logic [NO-1:0] osc_en,
  output logic          vreg_lp,
  output logic          vreg_off,
  output logic          nvm_off,
  output logic          wake_done
);
  always_comb begin
    cpu_clk_en  = 1'b0;
    bus_clk_en  = 1'b0;
    main_clk_en = 1'b0;
    gclk_en     = '0;
    vreg_lp     = 1'b0;
    vreg_off    = 1'b0;
    nvm_off     = 1'b0;
    wake_done   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        main_clk_en = 1'b1;
        bus_clk_en  = bus_clk_req;
        gclk_en     = '1;
      end
      ST_STBY: begin
        main_clk_en = bus_clk_req | (|gclk_req);
        bus_clk_en  = bus_clk_req;
        gclk_en     = gclk_req;
        vreg_lp     = 1'b1;
      end
      ST_OFF: begin
        vreg_off = 1'b1;
        nvm_off  = 1'b1;
      end
      ST_WK_MAIN: main_clk_en = 1'b1;
      ST_WK_BUS: begin
        main_clk_en = 1'b1;
        bus_clk_en  = 1'b1;
        gclk_en     = '1;
      end
      default: begin
        main_clk_en = 1'b1;
        bus_clk_en  = 1'b1;
        gclk_en     = '1;
        cpu_clk_en  = 1'b1;
        wake_done   = (state == ST_WK_DONE);
      end
    endcase
  end

  for (genvar g = 0; g < NO; g++) begin : g_osc
    assign osc_en[g] = (state == ST_OFF)  ? 1'b0 :
                       (state == ST_STBY) ? (osc_req[g] | osc_rstby[g]) : 1'b1;
  end
endmodule

// File: rtl/slp_seq_top.sv
module slp_seq_top
  import slp_pkg::*;
#(
  parameter int NP  = 4,
  parameter int NO  = 2,
  parameter int NG  = 3,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [1:0]    cfg_wdata,
  output logic [1:0]    cfg_rdata,
  input  logic          wfi_req,
  input  logic [NP-1:0] sync_wake,
  input  logic          async_wake,
  input  logic [NP-1:0] rstby_mask,
  input  logic [NO-1:0] osc_req,
  input  logic [NO-1:0] osc_rstby,
  input  logic          bus_clk_req,
  input  logic [NG-1:0] gclk_req,
  input  logic          vreg_ready,
  output logic          cpu_clk_en,
  output logic          bus_clk_en,
  output logic          main_clk_en,
  output logic [NG-1:0] gclk_en,
  output logic [NO-1:0] osc_en,
  output logic          vreg_lp,
  output logic          vreg_off,
  output logic          nvm_off,
  output logic          wake_done
);
  logic rst_int_n;
  lvl_e level;
  logic wake_light, wake_deep;
  st_e  state;

  slp_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  slp_cfg_bridge #(.LAT(LAT)) cfg_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cfg_wr_en),
    .wdata(cfg_wdata), .level(level)
  );

  assign cfg_rdata = level;

  slp_wake_qual #(.NP(NP)) wq_i (
    .sync_wake(sync_wake), .rstby_mask(rstby_mask), .async_wake(async_wake),
    .wake_light(wake_light), .wake_deep(wake_deep)
  );

  slp_fsm fsm_i (
    .clk(clk), .rst_n(rst_int_n), .wfi_req(wfi_req), .level(level),
    .vreg_ready(vreg_ready), .wake_light(wake_light), .wake_deep(wake_deep),
    .state(state)
  );

  slp_clk_gate #(.NO(NO), .NG(NG)) gate_i (
    .state(state), .bus_clk_req(bus_clk_req), .gclk_req(gclk_req),
    .osc_req(osc_req), .osc_rstby(osc_rstby),
    .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .main_clk_en(main_clk_en),
    .gclk_en(gclk_en), .osc_en(osc_en), .vreg_lp(vreg_lp), .vreg_off(vreg_off),
    .nvm_off(nvm_off), .wake_done(wake_done)
  );
endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk #(
  parameter int NO = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_rdata,
  input logic          vreg_ready,
  input logic          cpu_clk_en,
  input logic          bus_clk_en,
  input logic          main_clk_en,
  input logic [NO-1:0] osc_en,
  input logic          vreg_lp,
  input logic          vreg_off,
  input logic          nvm_off,
  input logic          wake_done
);
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata != 2'd3); // R2
  AST_IDLE_MAIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !vreg_lp && !vreg_off) |-> main_clk_en); // R4
  AST_LP_CPU_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_lp |-> !cpu_clk_en); // R5
  AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_off |-> (!cpu_clk_en && !bus_clk_en && !main_clk_en && osc_en == '0 && nvm_off)); // R8
  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_off |=> vreg_off); // R8
  AST_LP_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vreg_lp) |-> $past(vreg_ready)); // R9
  AST_CPU_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> ($past(bus_clk_en) && $past(main_clk_en))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done); // R10
  AST_DONE_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (cpu_clk_en && $past(cpu_clk_en))); // R10
endmodule

bind slp_seq_top slp_seq_chk #(.NO(NO)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .vreg_ready(vreg_ready),
  .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .main_clk_en(main_clk_en),
  .osc_en(osc_en), .vreg_lp(vreg_lp), .vreg_off(vreg_off), .nvm_off(nvm_off),
  .wake_done(wake_done)
);

// File: tb/slp_seq_top_tb_top.sv
module slp_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NO = 2;
  localparam int NG = 3;

  logic          clk, rst_n;
  logic          cfg_wr_en;
  logic [1:0]    cfg_wdata, cfg_rdata;
  logic          wfi_req;
  logic [NP-1:0] sync_wake, rstby_mask;
  logic          async_wake;
  logic [NO-1:0] osc_req, osc_rstby, osc_en;
  logic          bus_clk_req;
  logic [NG-1:0] gclk_req, gclk_en;
  logic          vreg_ready;
  logic          cpu_clk_en, bus_clk_en, main_clk_en;
  logic          vreg_lp, vreg_off, nvm_off, wake_done;

  int checks = 0;
  int fails  = 0;

  slp_seq_top #(.NP(NP), .NO(NO), .NG(NG), .LAT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wfi_req(wfi_req), .sync_wake(sync_wake),
    .async_wake(async_wake), .rstby_mask(rstby_mask), .osc_req(osc_req),
    .osc_rstby(osc_rstby), .bus_clk_req(bus_clk_req), .gclk_req(gclk_req),
    .vreg_ready(vreg_ready), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .main_clk_en(main_clk_en), .gclk_en(gclk_en), .osc_en(osc_en),
    .vreg_lp(vreg_lp), .vreg_off(vreg_off), .nvm_off(nvm_off), .wake_done(wake_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {cpu, bus, main, gclk[2:0], osc[1:0], lp, off, nvm, done}
  function automatic logic [31:0] outs();
    return {20'd0, cpu_clk_en, bus_clk_en, main_clk_en, gclk_en, osc_en,
            vreg_lp, vreg_off, nvm_off, wake_done};
  endfunction

  function automatic logic [31:0] pack(input logic c, b, m, input logic [2:0] g,
                                       input logic [1:0] o, input logic lp, off, nvm, dn);
    return {20'd0, c, b, m, g, o, lp, off, nvm, dn};
  endfunction

  task automatic write_cfg(input logic [1:0] code, input logic taken);
    logic [1:0] old;
    old = cfg_rdata;
    cfg_wr_en = 1'b1;
    cfg_wdata = code;
    tick();
    cfg_wr_en = 1'b0;
    check("R2 readback after edge k", 32'(cfg_rdata), 32'(old));
    tick();
    check("R2 readback after edge k+1", 32'(cfg_rdata), 32'(old));
    tick();
    check("R2 readback after edge k+2", 32'(cfg_rdata), taken ? 32'(code) : 32'(old));
  endtask

  task automatic do_wfi();
    wfi_req = 1'b1;
    tick();
    wfi_req = 1'b0;
  endtask

  // wake input already driven; this samples it and walks the staircase
  task automatic wake_stairs(input string tag);
    tick();
    sync_wake  = '0;
    async_wake = 1'b0;
    check({tag, " R10 step1 main+osc"}, outs(), pack(0,0,1,3'b000,2'b11,0,0,0,0));
    tick();
    check({tag, " R10 step2 bus+gclk"}, outs(), pack(0,1,1,3'b111,2'b11,0,0,0,0));
    tick();
    check({tag, " R10 step3 cpu"},      outs(), pack(1,1,1,3'b111,2'b11,0,0,0,0));
    tick();
    check({tag, " R10 done pulse"},     outs(), pack(1,1,1,3'b111,2'b11,0,0,0,1));
    tick();
    check({tag, " R10 pulse ends"},     outs(), pack(1,1,1,3'b111,2'b11,0,0,0,0));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    cfg_wr_en = 0; cfg_wdata = 0; wfi_req = 0; sync_wake = '0; async_wake = 0;
    rstby_mask = '0; osc_req = '0; osc_rstby = '0; bus_clk_req = 0; gclk_req = '0;
    vreg_ready = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    check("R1 reset outputs", outs(), pack(1,1,1,3'b111,2'b11,0,0,0,0));
    check("R1 reset level", 32'(cfg_rdata), 32'd0);

    // R2: reserved code ignored, legal code lands after two cycles
    write_cfg(2'd3, 1'b0);
    write_cfg(2'd1, 1'b1);
    write_cfg(2'd0, 1'b1);

    // R6 / R4: idle, each wake source (index NP means async)
    for (int s = 0; s <= NP; s++) begin
      do_wfi();
      bus_clk_req = s[0];
      #1;
      check("R4 idle outputs", outs(), pack(0,s[0],1,3'b111,2'b11,0,0,0,0));
      tick();
      check("R6 idle holds without wake", 32'(cpu_clk_en), 32'd0);
      bus_clk_req = 1'b0;
      if (s == NP) async_wake = 1'b1;
      else         sync_wake  = NP'(1 << s);
      wake_stairs("R6 idle wake");
    end

    // R3: wfi one cycle after a write still in flight uses old level (idle)
    cfg_wr_en = 1'b1; cfg_wdata = 2'd1;
    tick();
    cfg_wr_en = 1'b0;
    do_wfi();
    check("R3 old level used", outs(), pack(0,0,1,3'b111,2'b11,0,0,0,0));
    tick();
    check("R3 new level stored", 32'(cfg_rdata), 32'd1);
    check("R3 still idle not standby", 32'(vreg_lp), 32'd0);
    async_wake = 1'b1;
    wake_stairs("R3 exit");

    // R5: standby output sweep
    do_wfi();
    for (int o = 0; o < 4; o++)
      for (int r = 0; r < 4; r++)
        for (int g = 0; g < 8; g++)
          for (int b = 0; b < 2; b++) begin
            osc_req = NO'(o); osc_rstby = NO'(r);
            gclk_req = NG'(g); bus_clk_req = b[0];
            #1;
            check("R5 standby outputs", outs(),
                  pack(0, b[0], b[0] | (g != 0), 3'(g), 2'(o | r), 1, 0, 0, 0));
          end
    osc_req = '0; osc_rstby = '0; gclk_req = '0; bus_clk_req = 1'b0;
    async_wake = 1'b1;
    wake_stairs("R7 async");

    // R7: every sync source under every run-in-standby mask
    for (int m = 0; m < 16; m++)
      for (int i = 0; i < NP; i++) begin
        rstby_mask = NP'(m);
        do_wfi();
        sync_wake = NP'(1 << i);
        tick();
        sync_wake = '0;
        check("R7 standby sync qualification", 32'(main_clk_en), 32'(m[i]));
        if (!m[i]) begin
          check("R7 unmasked sync ignored", 32'(vreg_lp), 32'd1);
          async_wake = 1'b1;
          wake_stairs("R7 masked exit");
        end else begin
          repeat (4) tick();
          check("R7 back to run", outs(), pack(1,1,1,3'b111,2'b11,0,0,0,0));
        end
      end
    rstby_mask = '0;

    // R9: standby blocked until regulator ready
    vreg_ready = 1'b0;
    do_wfi();
    check("R9 clocks kept while not ready", outs(), pack(1,1,1,3'b111,2'b11,0,0,0,0));
    repeat (3) tick();
    check("R9 still waiting", 32'(vreg_lp), 32'd0);
    vreg_ready = 1'b1;
    tick();
    check("R9 standby after ready", outs(), pack(0,0,0,3'b000,2'b00,1,0,0,0));
    async_wake = 1'b1;
    wake_stairs("R9 exit");
    vreg_ready = 1'b0;
    do_wfi();
    async_wake = 1'b1;
    tick();
    async_wake = 1'b0;
    check("R9 cancel returns to run", outs(), pack(1,1,1,3'b111,2'b11,0,0,0,0));
    vreg_ready = 1'b1;
    tick();
    check("R9 no late standby after cancel", 32'(vreg_lp), 32'd0);

    // R8: off ignores all wakes, left only through reset
    write_cfg(2'd2, 1'b1);
    do_wfi();
    check("R8 off outputs", outs(), pack(0,0,0,3'b000,2'b00,0,1,1,0));
    sync_wake = '1; async_wake = 1'b1; rstby_mask = '1;
    bus_clk_req = 1'b1; gclk_req = '1; osc_req = '1;
    repeat (3) tick();
    check("R8 off ignores wakes", outs(), pack(0,0,0,3'b000,2'b00,0,1,1,0));
    sync_wake = '0; async_wake = 1'b0; rstby_mask = '0;
    bus_clk_req = 1'b0; gclk_req = '0; osc_req = '0;
    do_reset();
    check("R1 R8 reset leaves off", outs(), pack(1,1,1,3'b111,2'b11,0,0,0,0));
    check("R1 level back to idle", 32'(cfg_rdata), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule